// File: doc/BRIEF.md
# Dual Programmable Ratio Divider

This block holds the two digital dividers that feed a phase comparator in a frequency synthesiser. The reference path divides an input clock by a 7-bit word plus a constant of two. The feedback path divides an oscillator clock by a 9-bit word plus eight, and then by a further factor of two. Each path runs entirely on its own clock. It emits a single-cycle tick when each division period completes.

The words may be changed while the dividers run, for example from a parallel port. A new word is loaded only when the current period finishes, so a period is never cut short or stretched by a change. An input selects a restricted mode. In that mode some small word values are forbidden. A combinational error flag reports these values, and the dividers carry on counting with them.

Top module: `dual_ratio_divider`

## Requirements
- R1: The reference tick repeats every `ref_word + 2` cycles of `ref_clk`, giving ratios from 2 (word 0) to 129 (word 127).
- R2: The feedback tick repeats every `2 * (fb_word + 8)` cycles of `fb_clk`, giving ratios from 16 (word 0) to 1038 (word 511).
- R3: Each tick is high for exactly one cycle of its own clock, at the end of every division period.
- R4: A word change made part-way through a period leaves that period at its old length. The following period uses the new word.
- R5: With `restrict_en` = 1, `cfg_err` is 1 whenever `ref_word` equals 0.
- R6: With `restrict_en` = 1, `cfg_err` is 1 whenever `fb_word` is 0, 1, 2 or 3. If neither R5 nor R6 applies, `cfg_err` is 0.
- R7: With `restrict_en` = 0, `cfg_err` is 0 for every word value.
- R8: While `cfg_err` is 1, both dividers keep producing ticks at the ratios of R1 and R2.
- R9: A cycle with `rst_n` = 0, sampled on each path's clock, clears that path and holds its tick at 0. After release, the first tick comes exactly one full ratio of cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference input clock |
| fb_clk | input | 1 | Oscillator (feedback) clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| restrict_en | input | 1 | 1 selects the restricted variant with forbidden words |
| ref_word | input | 7 | Reference divide word |
| fb_word | input | 9 | Feedback divide word |
| ref_tick | output | 1 | One-cycle pulse on `ref_clk` per reference period |
| fb_tick | output | 1 | One-cycle pulse on `fb_clk` per feedback period |
| cfg_err | output | 1 | Combinational forbidden-word flag |

## Verification
A word change can coincide with a period boundary, or arrive in the middle of a period. The bench provokes the mid-period case by changing the word a few cycles after a tick. It then requires that the next interval still has the old length and that the interval after it has the new length. The forbidden-word flag and the running divider share the same cycles. The bench therefore sweeps words that raise `cfg_err` in restricted mode and, in those same cycles, measures the periods against the arithmetic ratio.

// File: rtl/ratio_div_pkg.sv
`timescale 1ns/1ps
package ratio_div_pkg;
    localparam int REF_W       = 7;
    localparam int FB_W        = 9;
    localparam int REF_OFS     = 2;
    localparam int FB_OFS      = 8;
    localparam int REF_MUL     = 1;
    localparam int FB_MUL      = 2;
    localparam int REF_MIN_OK  = 1;
    localparam int FB_MIN_OK   = 4;
endpackage

// File: rtl/ratio_counter.sv
`timescale 1ns/1ps
module ratio_counter #(
    parameter int WW     = 7,
    parameter int OFFSET = 2,
    parameter int MUL    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] word,
    output logic          tick
);
    localparam int MAXR = ((1 << WW) - 1 + OFFSET) * MUL;
    localparam int CW   = $clog2(MAXR);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          tick;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] word_lim;

    assign word_lim = CW'((32'(word) + OFFSET) * MUL - 1);

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == st_q.lim) begin
            st_d.cnt  = '0;
            st_d.lim  = word_lim;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!rst_n) begin
            st_d.cnt  = '0;
            st_d.lim  = word_lim;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R3: a tick never lasts two cycles
    a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);
    // R3: a tick marks the start of a fresh count
    a_r3_tick_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> (st_q.cnt == '0));
    // R4: the latched limit holds in mid-period
    a_r4_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && st_q.cnt != st_q.lim) |=> $stable(st_q.lim));
    // R1 R2: the count never passes the latched limit
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt <= st_q.lim) |=> (st_q.cnt <= st_q.lim));
endmodule

// File: rtl/word_guard.sv
`timescale 1ns/1ps
module word_guard #(
    parameter int RW     = 7,
    parameter int FW     = 9,
    parameter int R_MIN  = 1,
    parameter int F_MIN  = 4
) (
    input  logic          restrict_en,
    input  logic [RW-1:0] ref_word,
    input  logic [FW-1:0] fb_word,
    output logic          err
);
    logic ref_bad, fb_bad;

    always_comb begin
        ref_bad = (32'(ref_word) < R_MIN);
        fb_bad  = (32'(fb_word) < F_MIN);
        err     = restrict_en && (ref_bad || fb_bad);
    end
endmodule

// File: rtl/dual_ratio_divider.sv
`timescale 1ns/1ps
module dual_ratio_divider
    import ratio_div_pkg::*;
(
    input  logic             ref_clk,
    input  logic             fb_clk,
    input  logic             rst_n,
    input  logic             restrict_en,
    input  logic [REF_W-1:0] ref_word,
    input  logic [FB_W-1:0]  fb_word,
    output logic             ref_tick,
    output logic             fb_tick,
    output logic             cfg_err
);
    ratio_counter #(.WW(REF_W), .OFFSET(REF_OFS), .MUL(REF_MUL)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .word(ref_word), .tick(ref_tick));

    ratio_counter #(.WW(FB_W), .OFFSET(FB_OFS), .MUL(FB_MUL)) u_fb (
        .clk(fb_clk), .rst_n(rst_n), .word(fb_word), .tick(fb_tick));

    word_guard #(.RW(REF_W), .FW(FB_W), .R_MIN(REF_MIN_OK), .F_MIN(FB_MIN_OK)) u_guard (
        .restrict_en(restrict_en), .ref_word(ref_word), .fb_word(fb_word), .err(cfg_err));

    // R7: the flag stays low in the unrestricted variant
    always_comb begin
        if (!restrict_en)
            a_r7_no_err_free: assert (!cfg_err);
    end
    // R9: ticks stay low in the cycle after a reset cycle
    a_r9_ref_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ref_tick);
    a_r9_fb_quiet: assert property (@(posedge fb_clk) disable iff (!rst_n)
        $past(!rst_n) |-> !fb_tick);
endmodule

// File: tb/dual_ratio_divider_tb.sv
`timescale 1ns/1ps
module dual_ratio_divider_tb;
    logic ref_clk = 0, fb_clk = 0, rst_n = 0, restrict_en = 0;
    logic [6:0] ref_word = 7'd5;
    logic [8:0] fb_word  = 9'd0;
    logic ref_tick, fb_tick, cfg_err;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 ref_clk = ~ref_clk;
    always #1.5 fb_clk = ~fb_clk;

    dual_ratio_divider u_dut (.ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n),
        .restrict_en(restrict_en), .ref_word(ref_word), .fb_word(fb_word),
        .ref_tick(ref_tick), .fb_tick(fb_tick), .cfg_err(cfg_err));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_sync();
        @(negedge ref_clk);
        while (!ref_tick) @(negedge ref_clk);
    endtask
    task automatic ref_period(output int n);
        n = 0;
        do begin @(negedge ref_clk); n++; end while (!ref_tick);
    endtask
    task automatic fb_sync();
        @(negedge fb_clk);
        while (!fb_tick) @(negedge fb_clk);
    endtask
    task automatic fb_period(output int n);
        n = 0;
        do begin @(negedge fb_clk); n++; end while (!fb_tick);
    endtask

    function automatic int exp_err(input int rw, input int fw, input bit r);
        return (r && (rw == 0 || fw < 4)) ? 1 : 0;
    endfunction

    initial begin
        int n;
        repeat (4) @(negedge ref_clk);
        chk("R9 ref tick in reset", ref_tick, 0);
        chk("R9 fb tick in reset", fb_tick, 0);
        chk("R7 no err unrestricted", cfg_err, 0);
        // R9: first tick one full ratio after release
        rst_n = 1;
        ref_period(n);
        chk("R9 first ref tick", n, 7);
        // R1 R5 R8: sweep all reference words in restricted mode
        restrict_en = 1;
        fb_word = 9'd20;
        for (int w = 0; w < 128; w++) begin
            ref_word = 7'(w);
            #0.1;
            chk("R5 flag on ref word", cfg_err, exp_err(w, 20, 1));
            ref_sync();
            ref_period(n);
            chk("R1 ref ratio", n, w + 2);
        end
        // R3: pulse width at a ratio of 12
        ref_word = 7'd10;
        ref_sync();
        @(negedge ref_clk);
        chk("R3 tick one cycle", ref_tick, 0);
        // R4: change in mid-period
        ref_sync();
        n = 0;
        do begin
            @(negedge ref_clk); n++;
            if (n == 3) ref_word = 7'd30;
        end while (!ref_tick);
        chk("R4 old period kept", n, 12);
        ref_period(n);
        chk("R4 new period used", n, 32);
        // R6 R7: flag over small feedback words
        for (int f = 0; f < 6; f++) begin
            for (int r = 0; r < 2; r++) begin
                restrict_en = r[0];
                fb_word = 9'(f);
                ref_word = 7'd9;
                #0.1;
                chk(r ? "R6 flag on fb word" : "R7 flag off", cfg_err, exp_err(9, f, r[0]));
            end
        end
        restrict_en = 0;
        ref_word = 7'd0;
        #0.1;
        chk("R7 ref word 0 free", cfg_err, 0);
        // R2 R8: feedback sweep, restricted so low words raise the flag
        restrict_en = 1;
        ref_word = 7'd3;
        for (int i = 0; i < 12; i++) begin
            int w;
            w = (i < 8) ? i : (i == 8 ? 100 : (i == 9 ? 255 : (i == 10 ? 510 : 511)));
            fb_word = 9'(w);
            fb_sync();
            chk("R8 flag during run", cfg_err, exp_err(3, w, 1));
            fb_period(n);
            chk("R2 fb ratio", n, 2 * (w + 8));
        end
        // R9: reset mid-run clears and restarts
        fb_word = 9'd0;
        @(negedge fb_clk);
        rst_n = 0;
        repeat (3) @(negedge ref_clk);
        chk("R9 ref quiet in reset", ref_tick, 0);
        chk("R9 fb quiet in reset", fb_tick, 0);
        @(negedge fb_clk);
        rst_n = 1;
        fb_period(n);
        chk("R9 first fb tick", n, 16);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge ref_clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule